// File: doc/BRIEF.md
# Training Word Alignment Controller

This block finds the word boundary of one deserialized receive channel. The channel passes through a bit-slip realigner that moves the data by one bit each time its slip control goes from low to high. The block watches the parallel word coming out of that realigner and compares it against an expected training word supplied on a port. When they differ, it sends one slip pulse. It then waits for the realigner's pipeline to deliver a word that shows the slip, and judges again. It repeats until the word matches, and then reports lock.

A search begins when `startReq` is seen in the idle state. It also begins again when `startReq` is seen after a lock or after a failure. A single word that happens to match is not trusted: lock needs several equal words in a row. If every one of the `WORD_W` bit rotations has been tried without a match, the block stops slipping and raises a failure flag. Each channel gets its own instance, because alignment is found separately for each channel.

Top module: `train_align_ctl`

## Requirements
- R1: After reset, `slipCtl`, `isLocked` and `isFailed` are low. Until `startReq` is sampled high, the block stays idle and sends no slip pulse, whatever `rxWord` carries.
- R2: Once a search is running, each sampled `rxWord` is compared with `expWord`. After `LOCK_RUN` (default 4) equal words in a row, `isLocked` goes high in the clock that follows the last of those words.
- R3: A sampled word that does not match (and does not exhaust the slip budget) makes `slipCtl` high for exactly one clock, in the clock right after that word was sampled. `slipCtl` is then low again, so every slip request is a new low-to-high change.
- R4: After each slip pulse, `slipCtl` stays low for one clock plus `SETTLE_CYCLES` (default 3) clocks. The words sampled in that window are ignored. The next comparison uses the word sampled `SETTLE_CYCLES`+2 clocks after the clock in which the pulse was visible.
- R5: A mismatch resets the count of matching words. A run shorter than `LOCK_RUN` never gives lock.
- R6: Once `MAX_SLIPS` (default 8) slips have been sent in a search, the next mismatch sets `isFailed`. No further slip pulse follows until a restart.
- R7: `isLocked` and `isFailed` are never high together. Each one holds until a restart.
- R8: `startReq` sampled in the locked or failed state clears both flags at the next clock and starts a fresh search. The match count and the slip budget both start again from zero.
- R9: `startReq` sampled while a search is running (comparing, pulsing or settling) has no effect.
- R10: While locked, changes on `rxWord` have no effect, and `isLocked` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Begins a search from the idle state, or restarts one from the locked or failed state |
| rxWord | input | WORD_W | Parallel word observed at the realigner output |
| expWord | input | WORD_W | Expected training word |
| slipCtl | output | 1 | Slip request to the realigner; each one-clock high pulse asks for one bit slip |
| isLocked | output | 1 | Alignment found |
| isFailed | output | 1 | Every rotation was tried and none matched |

## Verification
The assertions check on every clock the properties that hold from cycle to cycle:
- a slip pulse lasts exactly one clock and is followed by the settle wait;
- no slip pulse goes out while the block is failed;
- the match count and the slip count stay within their bounds;
- a mismatch never leads straight to lock;
- the two flags are never high together;
- lock holds while `startReq` is low.

The bench scenarios cover what needs a live realigner and whole searches:
- the number of slips needed to reach a given starting rotation;
- the exact clock at which lock follows a settle window;
- failure after a full rotation with no match;
- refusal to lock on a run of matches that is too short;
- restarts after lock and after failure;
- a `startReq` that arrives in the middle of a search.

// File: rtl/align_ctl_pkg.sv
package align_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PULSE_HIGH,
    ST_PULSE_LOW,
    ST_WAIT,
    ST_LOCKED,
    ST_FAIL
  } alignState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clrAll;      // new search: clear every counter
    logic bumpRun;     // one more matching word
    logic clrRun;      // mismatch: restart the match run
    logic bumpSlip;    // a slip pulse is being issued
    logic loadSettle;  // start the latency wait
    logic tickSettle;  // count the latency wait down
  } alignStrobe_t;

endpackage

// File: rtl/align_datapath.sv
module align_datapath
  import align_ctl_pkg::*;
#(
  parameter int WORD_W        = 8,
  parameter int SETTLE_CYCLES = 3,
  parameter int LOCK_RUN      = 4,
  parameter int MAX_SLIPS     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  alignStrobe_t      strobe,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] expWord,
  output logic              wordMatch,
  output logic              runComplete,
  output logic              budgetSpent,
  output logic              settleDone
);

  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int SLIP_W = $clog2(MAX_SLIPS + 1);
  localparam int SET_W  = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;

  localparam logic [RUN_W-1:0]  RUN_LAST   = RUN_W'(LOCK_RUN - 1);
  localparam logic [SLIP_W-1:0] SLIP_LIMIT = SLIP_W'(MAX_SLIPS);
  localparam logic [SET_W-1:0]  SET_LOAD   = SET_W'(SETTLE_CYCLES - 1);

  logic [WORD_W-1:0] laneDiff;
  logic [RUN_W-1:0]  runCnt;
  logic [SLIP_W-1:0] slipCnt;
  logic [SET_W-1:0]  settleCnt;

  // One comparison lane for each bit of the word
  for (genvar b = 0; b < WORD_W; b++) begin : g_lane
    assign laneDiff[b] = rxWord[b] ^ expWord[b];
  end

  assign wordMatch   = ~|laneDiff;
  assign runComplete = wordMatch && (runCnt == RUN_LAST);
  assign budgetSpent = (slipCnt == SLIP_LIMIT);
  assign settleDone  = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.clrAll || strobe.clrRun) begin
      runCnt <= '0;
    end else if (strobe.bumpRun) begin
      runCnt <= runCnt + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slipCnt <= '0;
    end else if (strobe.clrAll) begin
      slipCnt <= '0;
    end else if (strobe.bumpSlip) begin
      slipCnt <= slipCnt + SLIP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.clrAll) begin
      settleCnt <= '0;
    end else if (strobe.loadSettle) begin
      settleCnt <= SET_LOAD;
    end else if (strobe.tickSettle && !settleDone) begin
      settleCnt <= settleCnt - SET_W'(1);
    end
  end

  // R5: the match run never reaches the lock length while it is being counted
  p_run_bounded_r5 : assert property (@(posedge clk) disable iff (!rstN)
    runCnt < RUN_W'(LOCK_RUN));

  // R6: no more slips than the budget allows
  p_slip_cap_r6 : assert property (@(posedge clk) disable iff (!rstN)
    slipCnt <= SLIP_LIMIT);

  // R5: a mismatch empties the run at the next clock
  p_run_cleared_r5 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrRun |=> (runCnt == '0));

endmodule

// File: rtl/align_control.sv
module align_control
  import align_ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         wordMatch,
  input  logic         runComplete,
  input  logic         budgetSpent,
  input  logic         settleDone,
  output alignStrobe_t strobe,
  output logic         slipCtl,
  output logic         isLocked,
  output logic         isFailed
);

  alignState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.clrAll = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (wordMatch) begin
          if (runComplete) stateNext = ST_LOCKED;
          else             strobe.bumpRun = 1'b1;
        end else begin
          strobe.clrRun = 1'b1;
          stateNext     = budgetSpent ? ST_FAIL : ST_PULSE_HIGH;
        end
      end
      ST_PULSE_HIGH: begin
        strobe.bumpSlip = 1'b1;
        stateNext       = ST_PULSE_LOW;
      end
      ST_PULSE_LOW: begin
        strobe.loadSettle = 1'b1;
        stateNext         = ST_WAIT;
      end
      ST_WAIT: begin
        if (settleDone) stateNext = ST_CHECK;
        else            strobe.tickSettle = 1'b1;
      end
      ST_LOCKED, ST_FAIL: begin
        if (startReq) begin
          strobe.clrAll = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign slipCtl  = (state == ST_PULSE_HIGH);
  assign isLocked = (state == ST_LOCKED);
  assign isFailed = (state == ST_FAIL);

  // R3: a slip request is one clock wide, so every request is a new rising edge
  p_pulse_single_r3 : assert property (@(posedge clk) disable iff (!rstN)
    slipCtl |=> !slipCtl);

  // R4: the low half of the pulse always leads into the latency wait
  p_settle_follows_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE_LOW) |=> (state == ST_WAIT));

  // R6: a failed search sends no slips
  p_fail_quiet_r6 : assert property (@(posedge clk) disable iff (!rstN)
    isFailed |-> !slipCtl);

  // R7: the two flags exclude each other
  p_flags_exclusive_r7 : assert property (@(posedge clk) disable iff (!rstN)
    !(isLocked && isFailed));

  // R2: a mismatching word never leads straight to lock
  p_no_lock_on_miss_r2 : assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CHECK) && !wordMatch) |=> !isLocked);

  // R10: lock holds until a restart is requested
  p_lock_held_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (isLocked && !startReq) |=> isLocked);

endmodule

// File: rtl/train_align_ctl.sv
module train_align_ctl
  import align_ctl_pkg::*;
#(
  parameter int WORD_W        = 8,
  parameter int SETTLE_CYCLES = 3,
  parameter int LOCK_RUN      = 4,
  parameter int MAX_SLIPS     = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] expWord,
  output logic              slipCtl,
  output logic              isLocked,
  output logic              isFailed
);

  alignStrobe_t strobe;
  logic wordMatch, runComplete, budgetSpent, settleDone;

  align_datapath #(
    .WORD_W       (WORD_W),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .LOCK_RUN     (LOCK_RUN),
    .MAX_SLIPS    (MAX_SLIPS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxWord     (rxWord),
    .expWord    (expWord),
    .wordMatch  (wordMatch),
    .runComplete(runComplete),
    .budgetSpent(budgetSpent),
    .settleDone (settleDone)
  );

  align_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .wordMatch  (wordMatch),
    .runComplete(runComplete),
    .budgetSpent(budgetSpent),
    .settleDone (settleDone),
    .strobe     (strobe),
    .slipCtl    (slipCtl),
    .isLocked   (isLocked),
    .isFailed   (isFailed)
  );

endmodule

// File: tb/tb_train_align_ctl.sv
module tb_train_align_ctl;

  localparam int W = 8;
  localparam int S = 3;
  localparam int L = 4;
  localparam int M = 8;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] rxWord = '0;
  logic [W-1:0] expWord = '0;
  logic         slipCtl, isLocked, isFailed;

  train_align_ctl #(.WORD_W(W), .SETTLE_CYCLES(S), .LOCK_RUN(L), .MAX_SLIPS(M)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rxWord(rxWord),
    .expWord(expWord), .slipCtl(slipCtl), .isLocked(isLocked), .isFailed(isFailed)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // Behavioural reference: a busy countdown covers pulse, low and settle time
  int mBusy = 0, mRun = 0, mSlips = 0;
  bit mSearch = 0, mLocked = 0, mFailed = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mRun = 0; mSlips = 0;
      mSearch = 0; mLocked = 0; mFailed = 0;
    end else if (mBusy > 0) begin
      mBusy--;
    end else if (mLocked || mFailed || !mSearch) begin
      if (startReq) begin
        mLocked = 0; mFailed = 0; mSearch = 1; mRun = 0; mSlips = 0;
      end
    end else if (rxWord == expWord) begin
      mRun++;
      if (mRun == L) begin mLocked = 1; mSearch = 0; end
    end else begin
      mRun = 0;
      if (mSlips == M) begin mFailed = 1; mSearch = 0; end
      else begin mSlips++; mBusy = S + 2; end
    end
  end

  // Bench realigner: rotate left by one on each rising slip request, two word latency
  logic [W-1:0] baseWord = 8'h1D;
  int  offset = 0;
  bit  directMode = 0;
  logic [W-1:0] pipe0 = '0, pipe1 = '0;
  bit  prevSlip = 0;
  bit  havePrior = 0;
  int  lowRun = 0;
  int  pulses = 0;

  function automatic logic [W-1:0] rotl(logic [W-1:0] v, int n);
    logic [W-1:0] r = v;
    for (int i = 0; i < (n % W); i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    // Every-clock comparison with the reference
    chk(slipCtl == (mBusy == S + 2), "R3 slipCtl vs model", slipCtl, mBusy == S + 2);
    chk(isLocked == mLocked, "R2 isLocked vs model", isLocked, mLocked);
    chk(isFailed == mFailed, "R6 isFailed vs model", isFailed, mFailed);
    // Pulse shape
    if (slipCtl) begin
      if (prevSlip) chk(0, "R3 pulse wider than one clock", 2, 1);
      if (havePrior && lowRun < S + 2) chk(0, "R4 low gap between pulses", lowRun, S + 2);
      havePrior = 1; lowRun = 0; pulses++;
    end else begin
      lowRun++;
    end
    if (slipCtl && !prevSlip) offset++;
    prevSlip = slipCtl;
    pipe1 = pipe0;
    pipe0 = rotl(baseWord, offset);
    if (!directMode) rxWord = pipe1;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
  endtask

  initial begin
    // Reset
    expWord = 8'h1D;
    directMode = 1; rxWord = 8'h00;
    repeat (3) tick();
    chk(slipCtl == 0, "R1 slipCtl in reset", slipCtl, 0);
    chk(isLocked == 0, "R1 isLocked in reset", isLocked, 0);
    chk(isFailed == 0, "R1 isFailed in reset", isFailed, 0);
    rstN = 1'b1;
    pulses = 0;
    repeat (10) tick();
    chk(pulses == 0, "R1 no slip while idle", pulses, 0);

    // Realigner starts three bits off: five slips bring it round
    offset = 3; directMode = 0;
    repeat (3) tick();
    pulses = 0;
    pulseStart();
    for (int i = 0; i < 300 && !isLocked; i++) tick();
    chk(isLocked == 1, "R2 lock reached", isLocked, 1);
    chk(pulses == 5, "R3 slip count to reach rotation", pulses, 5);
    chk(isFailed == 0, "R7 no failure on lock", isFailed, 0);

    // R10: garbage while locked
    directMode = 1; pulses = 0;
    for (int i = 0; i < 10; i++) begin rxWord = 8'(i * 37 + 1); tick(); end
    chk(isLocked == 1, "R10 lock held on changing input", isLocked, 1);
    chk(pulses == 0, "R10 no slip while locked", pulses, 0);

    // R8: restart from lock with aligned data
    directMode = 0; repeat (3) tick();
    pulses = 0;
    pulseStart();
    chk(isLocked == 0, "R8 flag cleared on restart", isLocked, 0);
    repeat (L - 1) tick();
    chk(isLocked == 0, "R2 no lock before run length", isLocked, 0);
    tick();
    chk(isLocked == 1, "R8 relock after run of matches", isLocked, 1);
    chk(pulses == 0, "R8 no slips when aligned", pulses, 0);

    // R6: no rotation matches
    expWord = 8'hFF; pulses = 0;
    pulseStart();
    for (int i = 0; i < 300 && !isFailed; i++) tick();
    chk(isFailed == 1, "R6 failure flagged", isFailed, 1);
    chk(pulses == M, "R6 slips before failure", pulses, M);
    repeat (20) tick();
    chk(pulses == M, "R6 no slips after failure", pulses, M);
    chk(isFailed == 1 && isLocked == 0, "R7 failure held", isFailed, 1);

    // R5: three matches then a miss, then R9 start during settle
    expWord = 8'h1D; directMode = 1; rxWord = 8'h1D; pulses = 0;
    pulseStart();
    chk(isFailed == 0, "R8 failure cleared on restart", isFailed, 0);
    repeat (L - 1) tick();
    rxWord = 8'h00;
    tick();
    rxWord = 8'h1D;
    chk(isLocked == 0, "R5 short run gives no lock", isLocked, 0);
    tick();
    chk(pulses == 1, "R5 miss after short run slips", pulses, 1);
    tick();
    pulseStart();
    for (int i = 0; i < 40 && !isLocked; i++) tick();
    chk(isLocked == 1, "R9 lock despite start in search", isLocked, 1);
    chk(pulses == 1, "R9 start in search adds no slip", pulses, 1);

    // R4: words inside the settle window are ignored; exact lock clock
    rxWord = 8'h00; pulses = 0;
    pulseStart();
    tick();
    chk(slipCtl == 1, "R3 pulse in clock after miss", slipCtl, 1);
    for (int i = 0; i < S + 2; i++) begin
      rxWord = (i % 2) ? 8'h00 : 8'h5A;
      tick();
    end
    rxWord = 8'h1D;
    repeat (L - 1) tick();
    chk(isLocked == 0, "R4 not locked one clock early", isLocked, 0);
    tick();
    chk(isLocked == 1, "R4 lock at expected clock", isLocked, 1);
    chk(pulses == 1, "R4 window words cause no slip", pulses, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule